// File: doc/BRIEF.md
# Fetch Target Queue Prefetch Filter

This block holds predicted fetch-block addresses between a branch predictor and the instruction fetch stage. The predictor pushes addresses at the tail while fetch stalls. Fetch pops them from the head while the predictor stalls. The queue therefore absorbs stalls on either side and exposes a stream of future fetch addresses well ahead of the current one.

Each queued entry carries a probe mark with three states: unprobed, cache miss (worth prefetching) and cache hit (redundant). Whenever the cache reports an idle tag port, the block offers the oldest unprobed entry as a tag probe. The same-cycle hit/miss answer updates that entry's mark.

A scanner looks from head to tail for the oldest entry that has not yet been issued and that the selected filter policy accepts. It offers that entry on a prefetch request output. Under the strict policy only entries a probe has shown to miss are requested. Under the permissive policy every entry is requested unless a probe has shown it to hit. A flush input empties the queue after a misprediction.

Top module: `ftq_prefetch_filter`

## Requirements
- R1: After reset the queue is empty: `deq_valid_o`, `pf_valid_o` and `probe_valid_o` are low and `enq_ready_o` is high.
- R2: Addresses leave through `deq_addr_o` in the order they were accepted. Acceptance happens when `enq_valid_i` and `enq_ready_o` are both high at a clock edge. Removal happens when `deq_valid_o` and `deq_ready_i` are both high. `enq_ready_o` is low exactly when DEPTH entries are held, and an offer made while full is dropped.
- R3: `probe_valid_o` is high only while `port_idle_i` is high and an unprobed entry exists. `probe_addr_o` is then the address of the oldest unprobed entry.
- R4: A newly accepted entry is unprobed. A probe answered with `probe_hit_i`=1 marks the entry as a hit, and a probe answered with `probe_hit_i`=0 marks it as a miss.
- R5: With `mode_i`=0 (strict), only entries marked miss are requested. Unprobed and hit entries are never offered on `pf_valid_o`.
- R6: With `mode_i`=1 (permissive), unprobed and miss-marked entries are requested and hit-marked entries are skipped. The offered entry is always the oldest eligible one.
- R7: An entry is requested at most once. After a cycle with `pf_valid_o` and `pf_ready_i` both high, that entry is never offered again, in either mode.
- R8: In permissive mode, if the entry being probed in a cycle is also the prefetch candidate and the probe hits, `pf_valid_o` is held low in that cycle.
- R9: While `flush_i` is high, `pf_valid_o` and `probe_valid_o` are low and a same-cycle enqueue is dropped. In the next cycle the queue is empty.
- R10: While `port_idle_i` is low, no probe is offered and no mark changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the queue (misprediction) |
| mode_i | input | 1 | Filter policy: 0 strict, 1 permissive |
| enq_valid_i | input | 1 | Predictor offers an address |
| enq_addr_i | input | ADDR_W | Predicted fetch-block address |
| enq_ready_o | output | 1 | Queue has room |
| deq_valid_o | output | 1 | Head entry present |
| deq_addr_o | output | ADDR_W | Head address for fetch |
| deq_ready_i | input | 1 | Fetch takes the head |
| port_idle_i | input | 1 | A cache tag port is free this cycle |
| probe_valid_o | output | 1 | Tag probe request |
| probe_addr_o | output | ADDR_W | Address to probe |
| probe_hit_i | input | 1 | Same-cycle probe result, 1 = present in cache |
| pf_valid_o | output | 1 | Prefetch request |
| pf_addr_o | output | ADDR_W | Address to prefetch |
| pf_ready_i | input | 1 | Prefetch request accepted |

## Verification
Several properties are checked on every cycle. Probes appear only with an idle port. A full queue always presents a head. An empty queue never requests a prefetch. A stalled head keeps its address. A flush silences both request outputs and leaves the queue empty one cycle later.

Other properties depend on history and can only be shown by the bench's directed scenarios. These are the order of dequeued addresses, the oldest-first selection of probe and prefetch targets, and how each mark steers the two policies. The bench also shows that an issued entry is not requested again after a mode change and that a same-cycle hit suppresses a candidate.

// File: rtl/ftq_pkg.sv
package ftq_pkg;

  typedef enum logic [1:0] {
    MARK_NONE = 2'd0,
    MARK_MISS = 2'd1,
    MARK_HIT  = 2'd2
  } probe_mark_e;

  typedef enum logic {
    FILT_STRICT     = 1'b0,
    FILT_PERMISSIVE = 1'b1
  } filt_mode_e;

endpackage

// File: rtl/ftq_ptrs.sv
module ftq_ptrs #(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [PTR_W-1:0] head_d, tail_d;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    head_d  = head;
    tail_d  = tail;
    count_d = count;
    if (flush) begin
      head_d  = '0;
      tail_d  = '0;
      count_d = '0;
    end else begin
      if (push) tail_d = tail + 1'b1;
      if (pop)  head_d = head + 1'b1;
      case ({push, pop})
        2'b10:   count_d = count + 1'b1;
        2'b01:   count_d = count - 1'b1;
        default: count_d = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head_d;
      tail  <= tail_d;
      count <= count_d;
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/ftq_find_first.sv
module ftq_find_first #(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/ftq_entry_table.sv
module ftq_entry_table
  import ftq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [PTR_W-1:0]        wr_slot,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic                    mark_en,
  input  logic [PTR_W-1:0]        mark_slot,
  input  probe_mark_e             mark_val,
  input  logic                    iss_en,
  input  logic [PTR_W-1:0]        iss_slot,
  output logic [DEPTH-1:0][ADDR_W-1:0] addr_q,
  output probe_mark_e [DEPTH-1:0] mark_q,
  output logic [DEPTH-1:0]        issued_q
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic        wr_hit, mark_hit, iss_hit;
    probe_mark_e mark_d;
    logic        issued_d;

    assign wr_hit   = wr_en   && (wr_slot   == PTR_W'(s));
    assign mark_hit = mark_en && (mark_slot == PTR_W'(s));
    assign iss_hit  = iss_en  && (iss_slot  == PTR_W'(s));

    always_comb begin
      mark_d   = mark_q[s];
      issued_d = issued_q[s];
      if (wr_hit) begin
        mark_d   = MARK_NONE;
        issued_d = 1'b0;
      end else begin
        if (mark_hit) mark_d   = mark_val;
        if (iss_hit)  issued_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mark_q[s]   <= MARK_NONE;
        issued_q[s] <= 1'b0;
      end else begin
        mark_q[s]   <= mark_d;
        issued_q[s] <= issued_d;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_hit) addr_q[s] <= wr_addr;
    end
  end

endmodule

// File: rtl/ftq_prefetch_filter.sv
module ftq_prefetch_filter
  import ftq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              mode_i,
  input  logic              enq_valid_i,
  input  logic [ADDR_W-1:0] enq_addr_i,
  output logic              enq_ready_o,
  output logic              deq_valid_o,
  output logic [ADDR_W-1:0] deq_addr_o,
  input  logic              deq_ready_i,
  input  logic              port_idle_i,
  output logic              probe_valid_o,
  output logic [ADDR_W-1:0] probe_addr_o,
  input  logic              probe_hit_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o,
  input  logic              pf_ready_i
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             full, empty;
  logic             push, pop;

  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  probe_mark_e [DEPTH-1:0]      mark_q;
  logic [DEPTH-1:0]             issued_q;

  logic [DEPTH-1:0] probe_req, cand_req;
  logic             probe_found, cand_found;
  logic [PTR_W-1:0] probe_ord, cand_ord;
  logic [PTR_W-1:0] probe_slot, cand_slot;
  logic             hit_on_cand;
  filt_mode_e       mode;

  assign mode = filt_mode_e'(mode_i);

  assign push = enq_valid_i && enq_ready_o && !flush_i;
  assign pop  = deq_valid_o && deq_ready_i && !flush_i;

  ftq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush_i),
    .push  (push),
    .pop   (pop),
    .head  (head),
    .tail  (tail),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  // Per-position eligibility, indexed by age (0 = head).
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PTR_W-1:0] slot;
    logic             occ;
    assign slot = head + PTR_W'(k);
    assign occ  = (CNT_W'(k) < count);
    assign probe_req[k] = occ && (mark_q[slot] == MARK_NONE);
    always_comb begin
      if (mode == FILT_STRICT)
        cand_req[k] = occ && !issued_q[slot] && (mark_q[slot] == MARK_MISS);
      else
        cand_req[k] = occ && !issued_q[slot] && (mark_q[slot] != MARK_HIT);
    end
  end

  ftq_find_first #(.N(DEPTH)) u_probe_pick (
    .req   (probe_req),
    .found (probe_found),
    .idx   (probe_ord)
  );

  ftq_find_first #(.N(DEPTH)) u_cand_pick (
    .req   (cand_req),
    .found (cand_found),
    .idx   (cand_ord)
  );

  assign probe_slot = head + probe_ord;
  assign cand_slot  = head + cand_ord;

  assign probe_valid_o = port_idle_i && probe_found && !flush_i;
  assign probe_addr_o  = addr_q[probe_slot];

  assign hit_on_cand = probe_valid_o && probe_hit_i && (probe_slot == cand_slot);

  assign pf_valid_o = cand_found && !flush_i && !hit_on_cand;
  assign pf_addr_o  = addr_q[cand_slot];

  assign enq_ready_o = !full;
  assign deq_valid_o = !empty;
  assign deq_addr_o  = addr_q[head];

  ftq_entry_table #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (push),
    .wr_slot   (tail),
    .wr_addr   (enq_addr_i),
    .mark_en   (probe_valid_o),
    .mark_slot (probe_slot),
    .mark_val  (probe_hit_i ? MARK_HIT : MARK_MISS),
    .iss_en    (pf_valid_o && pf_ready_i),
    .iss_slot  (cand_slot),
    .addr_q    (addr_q),
    .mark_q    (mark_q),
    .issued_q  (issued_q)
  );

endmodule

// File: rtl/ftq_filter_checker.sv
module ftq_filter_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic              enq_ready_o,
  input logic              deq_valid_o,
  input logic [ADDR_W-1:0] deq_addr_o,
  input logic              deq_ready_i,
  input logic              port_idle_i,
  input logic              probe_valid_o,
  input logic              pf_valid_o
);

  a_r2_full_has_head: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_ready_o |-> deq_valid_o);

  a_r2_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid_o && !deq_ready_i && !flush_i) |=> (deq_valid_o && $stable(deq_addr_o)));

  a_r10_probe_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid_o |-> (port_idle_i && deq_valid_o));

  a_r6_empty_no_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    !deq_valid_o |-> !pf_valid_o);

  a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> (!pf_valid_o && !probe_valid_o));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!deq_valid_o && enq_ready_o));

endmodule

bind ftq_prefetch_filter ftq_filter_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush_i       (flush_i),
  .enq_ready_o   (enq_ready_o),
  .deq_valid_o   (deq_valid_o),
  .deq_addr_o    (deq_addr_o),
  .deq_ready_i   (deq_ready_i),
  .port_idle_i   (port_idle_i),
  .probe_valid_o (probe_valid_o),
  .pf_valid_o    (pf_valid_o)
);

// File: tb/ftq_prefetch_filter_bench.sv
`timescale 1ns/1ps
module ftq_prefetch_filter_bench;

  localparam int DEPTH  = 32;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n, flush_i, mode_i, enq_valid_i, deq_ready_i;
  logic port_idle_i, probe_hit_i, pf_ready_i;
  logic [ADDR_W-1:0] enq_addr_i;
  logic enq_ready_o, deq_valid_o, probe_valid_o, pf_valid_o;
  logic [ADDR_W-1:0] deq_addr_o, probe_addr_o, pf_addr_o;

  always #2.5 clk = ~clk;

  ftq_prefetch_filter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ftq_prefetch_filter (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .mode_i(mode_i),
    .enq_valid_i(enq_valid_i), .enq_addr_i(enq_addr_i), .enq_ready_o(enq_ready_o),
    .deq_valid_o(deq_valid_o), .deq_addr_o(deq_addr_o), .deq_ready_i(deq_ready_i),
    .port_idle_i(port_idle_i), .probe_valid_o(probe_valid_o),
    .probe_addr_o(probe_addr_o), .probe_hit_i(probe_hit_i),
    .pf_valid_o(pf_valid_o), .pf_addr_o(pf_addr_o), .pf_ready_i(pf_ready_i)
  );

  int checks = 0;
  int errors = 0;
  logic [ADDR_W-1:0] exp_q[$];
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [ADDR_W-1:0] act,
                     input logic [ADDR_W-1:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #1;
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  // Driver: offers one address for one cycle, records it if accepted.
  task automatic enq(input logic [ADDR_W-1:0] a);
    enq_valid_i = 1'b1;
    enq_addr_i  = a;
    smp();
    if (enq_ready_o && !flush_i) exp_q.push_back(a);
    nxt();
    enq_valid_i = 1'b0;
  endtask

  // Monitor: compares every dequeued address against the scoreboard (R2).
  always @(negedge clk) begin
    if (rst_n && deq_valid_o && deq_ready_i && !flush_i) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R2", deq_addr_o, '0, "dequeue with nothing expected");
      else
        chk(deq_addr_o == exp_q[0], "R2", deq_addr_o, exp_q[0], "dequeue order");
      if (exp_q.size() != 0) void'(exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [ADDR_W-1:0] A0 = 'h100, A1 = 'h140, A2 = 'h180, A3 = 'h1c0;
  localparam logic [ADDR_W-1:0] B0 = 'h2000, B1 = 'h2040;

  initial begin
    rst_n = 1'b0; flush_i = 1'b0; mode_i = 1'b1; enq_valid_i = 1'b0;
    enq_addr_i = '0; deq_ready_i = 1'b0; port_idle_i = 1'b0;
    probe_hit_i = 1'b0; pf_ready_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    smp();
    chk(!deq_valid_o, "R1", deq_valid_o, 0, "deq_valid after reset");
    chk(enq_ready_o, "R1", enq_ready_o, 1, "enq_ready after reset");
    chk(!pf_valid_o && !probe_valid_o, "R1", pf_valid_o, 0, "requests after reset");
    nxt();

    // Permissive mode, no idle port
    enq(A0); enq(A1); enq(A2); enq(A3);
    smp();
    chk(pf_valid_o && pf_addr_o == A0, "R6", pf_addr_o, A0, "unprobed head requested");
    chk(!probe_valid_o, "R10", probe_valid_o, 0, "no probe without idle port");
    nxt();

    port_idle_i = 1'b1; probe_hit_i = 1'b1;
    smp();
    chk(probe_valid_o && probe_addr_o == A0, "R3", probe_addr_o, A0, "oldest unprobed probed");
    chk(!pf_valid_o, "R8", pf_valid_o, 0, "hit on candidate suppresses request");
    nxt();

    probe_hit_i = 1'b0;
    smp();
    chk(probe_valid_o && probe_addr_o == A1, "R3", probe_addr_o, A1, "next unprobed probed");
    chk(pf_valid_o && pf_addr_o == A1, "R6", pf_addr_o, A1, "hit entry skipped");
    nxt();

    port_idle_i = 1'b0; mode_i = 1'b0; pf_ready_i = 1'b1;
    smp();
    chk(pf_valid_o && pf_addr_o == A1, "R5", pf_addr_o, A1, "strict: miss entry requested");
    nxt();

    pf_ready_i = 1'b0;
    smp();
    chk(!pf_valid_o, "R5", pf_valid_o, 0, "strict: unprobed entries not requested");
    nxt();

    mode_i = 1'b1; pf_ready_i = 1'b1;
    smp();
    chk(pf_valid_o && pf_addr_o == A2, "R7", pf_addr_o, A2, "issued entry not offered again");
    nxt();
    smp();
    chk(pf_valid_o && pf_addr_o == A3, "R6", pf_addr_o, A3, "oldest eligible next");
    nxt();
    pf_ready_i = 1'b0;
    smp();
    chk(!pf_valid_o, "R7", pf_valid_o, 0, "all issued, nothing offered");
    nxt();

    port_idle_i = 1'b1; probe_hit_i = 1'b0;
    smp();
    chk(probe_valid_o && probe_addr_o == A2, "R3", probe_addr_o, A2, "probe skips marked entries");
    nxt();
    port_idle_i = 1'b0; mode_i = 1'b0;
    smp();
    chk(!pf_valid_o, "R7", pf_valid_o, 0, "issued miss entry not offered in strict mode");
    nxt();

    deq_ready_i = 1'b1;
    repeat (4) nxt();
    deq_ready_i = 1'b0;
    smp();
    chk(!deq_valid_o, "R2", deq_valid_o, 0, "drained");
    nxt();

    // Fill to capacity
    for (int i = 0; i < DEPTH; i++) enq(ADDR_W'('h1000 + i * 'h40));
    smp();
    chk(!enq_ready_o, "R2", enq_ready_o, 0, "full after DEPTH entries");
    nxt();
    enq('hdead0);
    deq_ready_i = 1'b1;
    repeat (DEPTH) nxt();
    deq_ready_i = 1'b0;
    smp();
    chk(!deq_valid_o, "R2", deq_valid_o, 0, "empty after full drain");
    chk(exp_q.size() == 0, "R2", exp_q.size(), 0, "all expected entries seen");
    nxt();

    // Mark encoding
    enq(B0); enq(B1);
    mode_i = 1'b0; port_idle_i = 1'b1; probe_hit_i = 1'b0;
    smp();
    chk(probe_valid_o && probe_addr_o == B0, "R4", probe_addr_o, B0, "new entry unprobed");
    chk(!pf_valid_o, "R4", pf_valid_o, 0, "unprobed not strict-eligible");
    nxt();
    probe_hit_i = 1'b1;
    smp();
    chk(probe_addr_o == B1, "R4", probe_addr_o, B1, "second entry probed");
    chk(pf_valid_o && pf_addr_o == B0, "R4", pf_addr_o, B0, "miss marks entry eligible");
    nxt();
    port_idle_i = 1'b0; mode_i = 1'b1; pf_ready_i = 1'b1;
    smp();
    chk(pf_valid_o && pf_addr_o == B0, "R4", pf_addr_o, B0, "permissive offers B0");
    nxt();
    pf_ready_i = 1'b0;
    smp();
    chk(!pf_valid_o, "R4", pf_valid_o, 0, "hit marks entry ineligible");
    nxt();

    // Flush with a same-cycle enqueue
    flush_i = 1'b1; enq_valid_i = 1'b1; enq_addr_i = 'h3000; port_idle_i = 1'b1;
    smp();
    chk(!pf_valid_o && !probe_valid_o, "R9", pf_valid_o, 0, "requests quiet during flush");
    nxt();
    flush_i = 1'b0; enq_valid_i = 1'b0; port_idle_i = 1'b0;
    exp_q.delete();
    smp();
    chk(!deq_valid_o && enq_ready_o, "R9", deq_valid_o, 0, "empty after flush");
    nxt();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule